// File: doc/BRIEF.md
# Transmit Packet Ring with Status Completion

This block manages the transmit side of a shared packet area. A producer pushes variable-length packets into a circular byte buffer. Each packet is stored as a one-word length header followed by its payload bytes. Payloads that run past the last byte continue at offset zero. After every packet the write cursor is rounded up to a word boundary. A consumer reads the buffer through a word-wide read port. It learns how far valid data extends from a word-unit write index.

When the consumer has sent a frame, it posts a completion entry into a fixed-depth status ring. Each entry holds an update flag, the sent size and a success flag. A reclaim engine takes the entry at the acknowledge slot. It reads the length header at the acknowledge byte cursor, steps that cursor past the packet, clears the entry's flag and pulses a completion output. A new packet is admitted only when its length fits in the free space and the ring is not marked full. The ring is marked full when either the byte cursor or the status cursor catches up with its acknowledge counterpart.

Top module: `tx_pkt_ring`

## Requirements
- R1: After reset, free_bytes is 8188, wr_index is 0, and ring_full, wr_busy, done_vld and size_err are all 0.
- R2: On acceptance, the word at byte address cur/4 is written with the packet length in bits [13:0] and zero above. Payload byte k goes to byte address (cur+4+k) mod 8192, in word address/4 and byte lane address mod 4 (lane 0 = bits [7:0]).
- R3: A payload that passes byte 8191 continues at byte 0 with no gap.
- R4: One cycle after the last payload byte is taken (or after acceptance, for a zero-length packet), the byte cursor becomes the next multiple of 4, modulo 8192. wr_index equals that cursor divided by 4. wr_index changes at no other time.
- R5: free_bytes = (8192 − cur + ack) − 4 when cur ≥ ack, otherwise (ack − cur) − 4.
- R6: wr_accept is high only when wr_start is high, no packet is being filled, ring_full is low and wr_len ≤ free_bytes. A refused start, or payload bytes offered while idle, leave wr_index and free_bytes unchanged.
- R7: A status write to slot i sets that slot's update flag with the given size and success flag. When the slot at the acknowledge index has its flag set, the next clock advances the acknowledge byte cursor by (header length + 7) with bits [1:0] cleared, modulo 8192. The same clock pulses done_vld for one cycle with done_ok equal to the posted success flag and clears the flag, so the slot is not reclaimed again.
- R8: ring_full rises when, after a packet commit, the byte cursor equals the acknowledge byte cursor. Any completion clears ring_full. While it is set, no start is accepted.
- R9: size_err becomes 1 when a reclaimed entry's size differs from the length in the packet's header, and it stays at 1 until reset.
- R10: With 64 packets outstanding, ring_full is set even when bytes remain free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Producer requests to begin a packet |
| wr_len | input | 14 | Length of the requested packet in bytes |
| wr_accept | output | 1 | Start request taken this cycle |
| wr_busy | output | 1 | A packet's payload is being filled |
| wr_byte_vld | input | 1 | Payload byte present |
| wr_byte | input | 8 | Payload byte |
| wr_index | output | 11 | Committed write cursor in 32-bit words |
| free_bytes | output | 14 | Free bytes available for the next payload |
| ring_full | output | 1 | No packet can be admitted until a completion |
| rd_addr | input | 11 | Consumer word read address |
| rd_data | output | 32 | Read word, one cycle after rd_addr |
| sts_we | input | 1 | Post a completion entry |
| sts_idx | input | 6 | Status slot written |
| sts_size | input | 14 | Size of the sent frame |
| sts_ok | input | 1 | Frame sent successfully |
| done_vld | output | 1 | One packet reclaimed |
| done_ok | output | 1 | Success flag of the reclaimed packet |
| size_err | output | 1 | Sticky header/status size mismatch |

## Verification
A table of packet lengths covers the ways the cursor can round: a length that is already aligned, lengths one to three bytes short of a boundary, and an empty packet. Each tells apart a wrong rounding from a wrong header charge in the index and free-space values, and the read port confirms the header word and the byte-lane placement. One long packet starts near the top of the buffer and wraps. It lands the cursor below the acknowledge pointer and checks the bytes on both sides of the seam. Further tests exercise the free-space boundary: one byte too many is refused and the exact fit sets ring_full. Separate runs reach full through the byte cursor and through the 64 status slots, and a deliberately wrong completion size sets the sticky mismatch flag.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  localparam int unsigned HDR_BYTES = 4;

  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_FILL = 1'b1
  } wr_state_e;
endpackage

// File: rtl/tx_ring_store.sv
module tx_ring_store #(
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [3:0]    wbe,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata,
  input  logic [AW-1:0] haddr,
  output logic [31:0]   hdata
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[g]) begin
        lane_mem[waddr] <= wdata[8*g +: 8];
      end
    end

    always_ff @(posedge clk) begin
      rdata[8*g +: 8] <= lane_mem[raddr];
    end

    assign hdata[8*g +: 8] = lane_mem[haddr];
  end
endmodule

// File: rtl/tx_ring_writer.sv
module tx_ring_writer
  import tx_ring_pkg::*;
#(
  parameter int unsigned PW = 13,
  parameter int unsigned LW = 14,
  parameter int unsigned SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_start,
  input  logic [LW-1:0] wr_len,
  input  logic          wr_byte_vld,
  input  logic [7:0]    wr_byte,
  input  logic [PW-1:0] ack,
  input  logic [PW-1:0] ack_nx,
  input  logic [SW-1:0] sack_nx,
  input  logic          rc_fire,
  output logic          wr_accept,
  output logic          wr_busy,
  output logic [PW-1:0] cur,
  output logic [LW-1:0] free_bytes,
  output logic          ring_full,
  output logic          mem_we,
  output logic [PW-3:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be
);
  localparam logic [LW-1:0] BUF_L = LW'(1 << PW);
  localparam logic [PW-1:0] ALIGN = PW'(3);

  wr_state_e     state, state_n;
  logic [PW-1:0] cur_n, wp, wp_n, wp_plus;
  logic [LW-1:0] rem, rem_n, space;
  logic [SW-1:0] scur, scur_n;
  logic          full_n, commit, byte_go;

  // admission and free space
  always_comb begin
    if (cur >= ack) space = BUF_L - {1'b0, cur} + {1'b0, ack};
    else            space = {1'b0, ack} - {1'b0, cur};
    free_bytes = space - LW'(HDR_BYTES);
    wr_accept  = wr_start && (state == WS_IDLE) && !ring_full && (wr_len <= free_bytes);
    byte_go    = (state == WS_FILL) && wr_byte_vld;
    wp_plus    = wp + 1'b1;
  end

  // buffer write port: header word on accept, one byte lane while filling
  always_comb begin
    mem_we    = wr_accept || byte_go;
    mem_addr  = wr_accept ? cur[PW-1:2] : wp[PW-1:2];
    mem_wdata = wr_accept ? 32'(wr_len) : {4{wr_byte}};
    mem_be    = wr_accept ? 4'hF : (4'b0001 << wp[1:0]);
  end

  // next state
  always_comb begin
    state_n = state;
    cur_n   = cur;
    wp_n    = wp;
    rem_n   = rem;
    scur_n  = scur;
    full_n  = ring_full;
    commit  = 1'b0;
    if (wr_accept) begin
      if (wr_len == '0) begin
        commit = 1'b1;
        cur_n  = cur + PW'(HDR_BYTES);
      end else begin
        state_n = WS_FILL;
        wp_n    = cur + PW'(HDR_BYTES);
        rem_n   = wr_len;
      end
    end else if (byte_go) begin
      wp_n  = wp_plus;
      rem_n = rem - 1'b1;
      if (rem == LW'(1)) begin
        commit  = 1'b1;
        state_n = WS_IDLE;
        cur_n   = (wp_plus + ALIGN) & ~ALIGN;
      end
    end
    if (commit) begin
      scur_n = scur + 1'b1;
      full_n = (cur_n == ack_nx) || (scur_n == sack_nx);
    end else if (rc_fire) begin
      full_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= WS_IDLE;
      cur       <= '0;
      wp        <= '0;
      rem       <= '0;
      scur      <= '0;
      ring_full <= 1'b0;
    end else begin
      state     <= state_n;
      cur       <= cur_n;
      wp        <= wp_n;
      rem       <= rem_n;
      scur      <= scur_n;
      ring_full <= full_n;
    end
  end

  assign wr_busy = (state == WS_FILL);
endmodule

// File: rtl/tx_ring_reclaim.sv
module tx_ring_reclaim #(
  parameter int unsigned PW    = 13,
  parameter int unsigned LW    = 14,
  parameter int unsigned SW    = 6,
  parameter int unsigned DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sts_we,
  input  logic [SW-1:0] sts_idx,
  input  logic [LW-1:0] sts_size,
  input  logic          sts_ok,
  input  logic [31:0]   hdr_word,
  output logic [PW-3:0] hdr_addr,
  output logic [PW-1:0] ack,
  output logic [PW-1:0] ack_nx,
  output logic [SW-1:0] sack_nx,
  output logic          rc_fire,
  output logic          done_vld,
  output logic          done_ok,
  output logic          size_err
);
  localparam logic [PW-1:0] ALIGN = PW'(3);

  logic [DEPTH-1:0] upd, upd_n;
  logic [LW-1:0]    sz_mem [DEPTH];
  logic             ok_mem [DEPTH];
  logic [SW-1:0]    sack;
  logic [LW:0]      step_sum;
  logic             mismatch;

  always_comb begin
    rc_fire  = upd[sack];
    hdr_addr = ack[PW-1:2];
    step_sum = (LW+1)'(ack) + {1'b0, hdr_word[LW-1:0]} + (LW+1)'(7);
    ack_nx   = rc_fire ? (step_sum[PW-1:0] & ~ALIGN) : ack;
    sack_nx  = rc_fire ? sack + 1'b1 : sack;
    mismatch = rc_fire && ((hdr_word[LW-1:0] != sz_mem[sack]) || (hdr_word[31:LW] != '0));
    for (int i = 0; i < DEPTH; i++) begin
      upd_n[i] = upd[i];
      if (rc_fire && (sack == SW'(i))) upd_n[i] = 1'b0;
      if (sts_we && (sts_idx == SW'(i))) upd_n[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (sts_we) begin
      sz_mem[sts_idx] <= sts_size;
      ok_mem[sts_idx] <= sts_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd      <= '0;
      ack      <= '0;
      sack     <= '0;
      done_vld <= 1'b0;
      done_ok  <= 1'b0;
      size_err <= 1'b0;
    end else begin
      upd      <= upd_n;
      ack      <= ack_nx;
      sack     <= sack_nx;
      done_vld <= rc_fire;
      if (rc_fire) done_ok <= ok_mem[sack];
      if (mismatch) size_err <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_pkt_ring.sv
module tx_pkt_ring #(
  parameter int unsigned BUF_BYTES = 8192,
  parameter int unsigned STS_DEPTH = 64,
  localparam int unsigned PW = $clog2(BUF_BYTES),
  localparam int unsigned LW = PW + 1,
  localparam int unsigned AW = PW - 2,
  localparam int unsigned SW = $clog2(STS_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_start,
  input  logic [LW-1:0] wr_len,
  output logic          wr_accept,
  output logic          wr_busy,
  input  logic          wr_byte_vld,
  input  logic [7:0]    wr_byte,
  output logic [AW-1:0] wr_index,
  output logic [LW-1:0] free_bytes,
  output logic          ring_full,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  input  logic          sts_we,
  input  logic [SW-1:0] sts_idx,
  input  logic [LW-1:0] sts_size,
  input  logic          sts_ok,
  output logic          done_vld,
  output logic          done_ok,
  output logic          size_err
);
  logic [PW-1:0] cur, ack, ack_nx;
  logic [SW-1:0] sack_nx;
  logic          rc_fire, mem_we;
  logic [AW-1:0] mem_addr, hdr_addr;
  logic [31:0]   mem_wdata, hdr_word;
  logic [3:0]    mem_be;

  tx_ring_writer #(.PW(PW), .LW(LW), .SW(SW)) writer_i (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_len(wr_len),
    .wr_byte_vld(wr_byte_vld), .wr_byte(wr_byte), .ack(ack), .ack_nx(ack_nx),
    .sack_nx(sack_nx), .rc_fire(rc_fire), .wr_accept(wr_accept), .wr_busy(wr_busy),
    .cur(cur), .free_bytes(free_bytes), .ring_full(ring_full), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be)
  );

  tx_ring_store #(.AW(AW)) store_i (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata), .wbe(mem_be),
    .raddr(rd_addr), .rdata(rd_data), .haddr(hdr_addr), .hdata(hdr_word)
  );

  tx_ring_reclaim #(.PW(PW), .LW(LW), .SW(SW), .DEPTH(STS_DEPTH)) reclaim_i (
    .clk(clk), .rst_n(rst_n), .sts_we(sts_we), .sts_idx(sts_idx),
    .sts_size(sts_size), .sts_ok(sts_ok), .hdr_word(hdr_word), .hdr_addr(hdr_addr),
    .ack(ack), .ack_nx(ack_nx), .sack_nx(sack_nx), .rc_fire(rc_fire),
    .done_vld(done_vld), .done_ok(done_ok), .size_err(size_err)
  );

  assign wr_index = cur[PW-1:2];
endmodule

// File: rtl/tx_ring_chk.sv
module tx_ring_chk #(
  parameter int unsigned BUF_BYTES = 8192,
  parameter int unsigned LW        = 14,
  parameter int unsigned AW        = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_accept,
  input logic          wr_busy,
  input logic [AW-1:0] wr_index,
  input logic [LW-1:0] free_bytes,
  input logic          ring_full,
  input logic          size_err
);
  // R8
  full_blocks_admit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_full |-> !wr_accept);

  // R6
  busy_blocks_admit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !wr_accept);

  // R9
  size_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |=> size_err);

  // R5
  free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_bytes <= LW'(BUF_BYTES - 4));

  // R4
  index_moves_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_index) |-> ($past(wr_busy) || $past(wr_accept)));

  // R8
  full_rise_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ring_full) |-> ($past(wr_busy) || $past(wr_accept)));
endmodule

bind tx_pkt_ring tx_ring_chk #(.BUF_BYTES(BUF_BYTES), .LW(LW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_accept(wr_accept), .wr_busy(wr_busy),
  .wr_index(wr_index), .free_bytes(free_bytes), .ring_full(ring_full),
  .size_err(size_err)
);

// File: tb/tx_pkt_ring_tb.sv
`timescale 1ns/1ps
module tx_pkt_ring_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_start, wr_accept, wr_busy, wr_byte_vld;
  logic [13:0] wr_len, free_bytes, sts_size;
  logic [7:0]  wr_byte;
  logic [10:0] wr_index, rd_addr;
  logic [31:0] rd_data;
  logic        ring_full, sts_we, sts_ok, done_vld, done_ok, size_err;
  logic [5:0]  sts_idx;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tx_pkt_ring dut_i (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_len(wr_len),
    .wr_accept(wr_accept), .wr_busy(wr_busy), .wr_byte_vld(wr_byte_vld),
    .wr_byte(wr_byte), .wr_index(wr_index), .free_bytes(free_bytes),
    .ring_full(ring_full), .rd_addr(rd_addr), .rd_data(rd_data),
    .sts_we(sts_we), .sts_idx(sts_idx), .sts_size(sts_size), .sts_ok(sts_ok),
    .done_vld(done_vld), .done_ok(done_ok), .size_err(size_err)
  );

  // length, expected word index, expected free bytes
  localparam int VEC [6][3] = '{
    '{1, 2, 8180}, '{4, 4, 8172}, '{5, 7, 8160},
    '{0, 8, 8156}, '{10, 12, 8140}, '{3, 14, 8132}
  };

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'((i * 7 + s) & 255);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_pkt(input int len, input int seed, output bit acc);
    @(negedge clk);
    wr_start = 1'b1;
    wr_len   = 14'(len);
    #1 acc = wr_accept;
    @(negedge clk);
    wr_start = 1'b0;
    if (acc) begin
      for (int i = 0; i < len; i++) begin
        wr_byte_vld = 1'b1;
        wr_byte     = pat(i, seed);
        @(negedge clk);
      end
    end
    wr_byte_vld = 1'b0;
  endtask

  task automatic post_sts(input int idx, input int size, input bit ok);
    @(negedge clk);
    sts_we = 1'b1; sts_idx = 6'(idx); sts_size = 14'(size); sts_ok = ok;
    @(negedge clk);
    sts_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_word(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = 11'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit acc;
    logic [31:0] d;
    rst_n = 1'b0; wr_start = 1'b0; wr_len = '0; wr_byte_vld = 1'b0; wr_byte = '0;
    rd_addr = '0; sts_we = 1'b0; sts_idx = '0; sts_size = '0; sts_ok = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1 free", 32'(free_bytes), 8188);
    chk("R1 index", 32'(wr_index), 0);
    chk("R1 flags", {27'd0, ring_full, wr_busy, done_vld, size_err, wr_accept}, 0);

    // bytes offered while idle are ignored
    wr_byte_vld = 1'b1; wr_byte = 8'hAA;
    @(negedge clk);
    wr_byte_vld = 1'b0;
    @(negedge clk);
    chk("R6 idle byte index", 32'(wr_index), 0);
    chk("R6 idle byte free", 32'(free_bytes), 8188);

    for (int v = 0; v < 6; v++) begin
      send_pkt(VEC[v][0], v * 16 + 1, acc);
      chk("R6 accept", 32'(acc), 1);
      chk("R4 index", 32'(wr_index), 32'(VEC[v][1]));
      chk("R5 free", 32'(free_bytes), 32'(VEC[v][2]));
    end

    rd_word(0, d);  chk("R2 header word", d, 1);
    rd_word(1, d);  chk("R2 byte lane 0", 32'(d[7:0]), 32'(pat(0, 1)));
    rd_word(4, d);  chk("R2 header len5", d, 5);
    rd_word(5, d);  chk("R2 lane order", d, {pat(3, 33), pat(2, 33), pat(1, 33), pat(0, 33)});
    rd_word(6, d);  chk("R2 tail byte", 32'(d[7:0]), 32'(pat(4, 33)));

    for (int v = 0; v < 6; v++) begin
      post_sts(v, VEC[v][0], v != 2);
      chk("R7 done pulse", 32'(done_vld), 1);
      chk("R7 done ok", 32'(done_ok), 32'(v != 2));
      if (v == 0) chk("R7 ack step", 32'(free_bytes), 8140);
    end
    @(negedge clk);
    chk("R7 flag cleared", 32'(done_vld), 0);
    chk("R7 all reclaimed", 32'(free_bytes), 8188);
    chk("R9 matched sizes", 32'(size_err), 0);

    // wrapping packet: header at byte 56, payload 60..8209 mod 8192
    send_pkt(8150, 5, acc);
    chk("R3 accept", 32'(acc), 1);
    chk("R4 wrap index", 32'(wr_index), 5);
    chk("R5 free below ack", 32'(free_bytes), 32);
    rd_word(14, d);   chk("R2 long header", d, 8150);
    rd_word(2047, d); chk("R3 top word", d, {pat(8131, 5), pat(8130, 5), pat(8129, 5), pat(8128, 5)});
    rd_word(4, d);    chk("R3 wrapped bytes", 32'(d[15:0]), {16'd0, pat(8149, 5), pat(8148, 5)});

    send_pkt(33, 9, acc);
    chk("R6 oversize refused", 32'(acc), 0);
    chk("R6 refused index", 32'(wr_index), 5);
    send_pkt(32, 9, acc);
    chk("R6 exact fit", 32'(acc), 1);
    chk("R8 byte full", 32'(ring_full), 1);
    chk("R4 full index", 32'(wr_index), 14);
    send_pkt(0, 0, acc);
    chk("R8 refused while full", 32'(acc), 0);

    post_sts(6, 8150, 1'b1);
    chk("R8 completion clears", 32'(ring_full), 0);
    chk("R7 wrapped ack", 32'(free_bytes), 8152);
    post_sts(7, 31, 1'b1);
    chk("R9 mismatch", 32'(size_err), 1);
    chk("R7 ack after 32", 32'(free_bytes), 8188);

    for (int p = 0; p < 64; p++) begin
      send_pkt(0, 0, acc);
      if (p == 62) chk("R10 not yet full", 32'(ring_full), 0);
    end
    chk("R10 slot full", 32'(ring_full), 1);
    chk("R10 bytes remain", 32'(free_bytes), 7932);
    chk("R10 index", 32'(wr_index), 78);
    send_pkt(0, 0, acc);
    chk("R10 refused", 32'(acc), 0);
    post_sts(8, 0, 1'b1);
    chk("R10 cleared", 32'(ring_full), 0);
    chk("R9 sticky", 32'(size_err), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule